// File: doc/BRIEF.md
# Transceiver Lane Reset Sequencer

This block brings one high-speed serial transceiver lane out of reset in a fixed order. It drives four active-low reset outputs: a hard reset, a quiescent-current (low-power) control, a transmit-PCS reset and a receive-PCS reset. After the hard reset is let go, the block opens a configuration window of 1200 µs. During that window an outside agent may write the lane's configuration registers. When the window closes, the block frees the low-power control and then the transmit PCS. It waits 850 µs more before it frees the receive PCS and reports completion.

The waits are counted in cycles of the reference clock. The clock rate is given by the integer parameter `CLK_MHZ`, so a wait of N µs lasts exactly N × `CLK_MHZ` cycles. For simulation, a fast mode parameter replaces both waits with short cycle counts. Dynamic test features such as loopback, self-test and spread-spectrum clocking are gated off by an enable output until the sequence has finished.

A synchronous restart input restarts the whole sequence, and so does loss of the reference-clock-valid input. A small encoded state output shows how far the sequence has got.

Top module: `lane_reset_sequencer`

## Requirements
- R1: The hard reset (`hardRstN`) is always the first output released. While it is low, `lowPwrRstN`, `txPcsRstN`, `rxPcsRstN` and `progWindow` are all low.
- R2: `progWindow` goes high in the same cycle that `hardRstN` rises. It stays high for exactly `PROG_US`×`CLK_MHZ` cycles, or for `FAST_PROG_CYC` cycles when `FAST_SIM`=1.
- R3: While `progWindow` is high, `hardRstN` is high and `lowPwrRstN`, `txPcsRstN` and `rxPcsRstN` stay low.
- R4: `lowPwrRstN` rises in the first cycle after `progWindow` falls at the end of the window.
- R5: `txPcsRstN` rises exactly one cycle after `lowPwrRstN` rises.
- R6: `rxPcsRstN` rises after `txPcsRstN` has been high for exactly `RX_US`×`CLK_MHZ` cycles, or for `FAST_RX_CYC` cycles when `FAST_SIM`=1.
- R7: `testFeatEn` is low at all times before the sequence completes, and it equals `seqDone`.
- R8: `seqDone` rises in the same cycle as `rxPcsRstN`. It stays high until a restart condition occurs.
- R9: `seqState` encodes progress: 0 = idle (hard reset held), 1 = programming wait, 2 = transmit release, 3 = receive wait, 4 = done.
- R10: If `restart`=1 or `refClkValid`=0 at a clock edge, all reset outputs, `progWindow`, `seqDone` and `testFeatEn` are low after that edge, and `seqState` is 0. The sequence starts again from the first step at the first edge where the condition is gone. The asynchronous `rstN` gives the same state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| restart | input | 1 | Synchronous restart request, active high |
| refClkValid | input | 1 | High while the reference clock is trusted |
| hardRstN | output | 1 | Lane hard reset, active low |
| lowPwrRstN | output | 1 | Quiescent-current control reset, active low |
| txPcsRstN | output | 1 | Transmit PCS reset, active low |
| rxPcsRstN | output | 1 | Receive PCS reset, active low |
| progWindow | output | 1 | High while lane registers may be written |
| testFeatEn | output | 1 | Enable gate for loopback, self-test and spread-spectrum clocking |
| seqDone | output | 1 | Sequence complete |
| seqState | output | 3 | Encoded sequence state |

## Verification
Some properties hold in every cycle, and the assertions check these. No reset is released while the hard reset is held, and nothing is freed early while the window is open. The low-power control follows the window, and the transmit release follows the low-power release. Completion and the feature gate track the receive release, and any restart condition sends the block back to idle on the next edge. The exact lengths of the two waits can only be shown by the bench's scenarios, which count cycles. The same goes for a full restart in the middle of a sequence and for completion holding steady over many cycles. The bench compares every output each cycle against its own sequence model, while restarts and clock-valid drops arrive at random times.

// File: rtl/lane_rst_pkg.sv
package lane_rst_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_PROG   = 3'd1,
    ST_TXREL  = 3'd2,
    ST_RXWAIT = 3'd3,
    ST_DONE   = 3'd4
  } seqState_e;

  // strobes from the control FSM to the wait timer
  typedef struct packed {
    logic clear;
    logic loadProg;
    logic loadRx;
  } timerCtl_t;

endpackage

// File: rtl/lane_rst_timer.sv
module lane_rst_timer
  import lane_rst_pkg::*;
#(
  parameter int PROG_CYC = 120000,
  parameter int RX_CYC   = 85000
) (
  input  logic      clk,
  input  logic      rstN,
  input  timerCtl_t ctl,
  output logic      expired
);
  localparam int MAX_CYC = (PROG_CYC > RX_CYC) ? PROG_CYC : RX_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remain <= '0;
    end else if (ctl.clear) begin
      remain <= '0;
    end else if (ctl.loadProg) begin
      remain <= CNT_W'(PROG_CYC - 1);
    end else if (ctl.loadRx) begin
      remain <= CNT_W'(RX_CYC - 1);
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign expired = (remain == '0);
endmodule

// File: rtl/lane_rst_ctrl.sv
module lane_rst_ctrl
  import lane_rst_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      restart,
  input  logic      refClkValid,
  input  logic      expired,
  output seqState_e state,
  output timerCtl_t timerCtl
);
  logic      abort;
  seqState_e nextState;

  assign abort = restart || !refClkValid;

  always_comb begin
    nextState = state;
    if (abort) begin
      nextState = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE:   nextState = ST_PROG;
        ST_PROG:   if (expired) nextState = ST_TXREL;
        ST_TXREL:  nextState = ST_RXWAIT;
        ST_RXWAIT: if (expired) nextState = ST_DONE;
        ST_DONE:   nextState = ST_DONE;
        default:   nextState = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    timerCtl.clear    = abort;
    timerCtl.loadProg = !abort && (state == ST_IDLE);
    timerCtl.loadRx   = !abort && (state == ST_TXREL);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end
endmodule

// File: rtl/lane_rst_decode.sv
module lane_rst_decode
  import lane_rst_pkg::*;
(
  input  seqState_e   state,
  output logic        hardRstN,
  output logic        lowPwrRstN,
  output logic        txPcsRstN,
  output logic        rxPcsRstN,
  output logic        progWindow,
  output logic        seqDone
);
  always_comb begin
    hardRstN   = (state != ST_IDLE);
    progWindow = (state == ST_PROG);
    lowPwrRstN = (state == ST_TXREL) || (state == ST_RXWAIT) || (state == ST_DONE);
    txPcsRstN  = (state == ST_RXWAIT) || (state == ST_DONE);
    rxPcsRstN  = (state == ST_DONE);
    seqDone    = (state == ST_DONE);
  end
endmodule

// File: rtl/lane_reset_sequencer.sv
module lane_reset_sequencer
  import lane_rst_pkg::*;
#(
  parameter int CLK_MHZ       = 100,
  parameter int PROG_US       = 1200,
  parameter int RX_US         = 850,
  parameter bit FAST_SIM      = 1'b0,
  parameter int FAST_PROG_CYC = 40,
  parameter int FAST_RX_CYC   = 25
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       restart,
  input  logic       refClkValid,
  output logic       hardRstN,
  output logic       lowPwrRstN,
  output logic       txPcsRstN,
  output logic       rxPcsRstN,
  output logic       progWindow,
  output logic       testFeatEn,
  output logic       seqDone,
  output logic [2:0] seqState
);
  localparam int PROG_CYC = FAST_SIM ? FAST_PROG_CYC : PROG_US * CLK_MHZ;
  localparam int RX_CYC   = FAST_SIM ? FAST_RX_CYC   : RX_US * CLK_MHZ;

  seqState_e state;
  timerCtl_t timerCtl;
  logic      expired;
  logic      doneInt;

  lane_rst_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .restart    (restart),
    .refClkValid(refClkValid),
    .expired    (expired),
    .state      (state),
    .timerCtl   (timerCtl)
  );

  lane_rst_timer #(
    .PROG_CYC(PROG_CYC),
    .RX_CYC  (RX_CYC)
  ) u_timer (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (timerCtl),
    .expired(expired)
  );

  lane_rst_decode u_decode (
    .state     (state),
    .hardRstN  (hardRstN),
    .lowPwrRstN(lowPwrRstN),
    .txPcsRstN (txPcsRstN),
    .rxPcsRstN (rxPcsRstN),
    .progWindow(progWindow),
    .seqDone   (doneInt)
  );

  assign seqDone    = doneInt;
  assign testFeatEn = doneInt;
  assign seqState   = state;
endmodule

// File: rtl/lane_reset_sequencer_chk.sv
module lane_reset_sequencer_chk (
  input logic       clk,
  input logic       rstN,
  input logic       restart,
  input logic       refClkValid,
  input logic       hardRstN,
  input logic       lowPwrRstN,
  input logic       txPcsRstN,
  input logic       rxPcsRstN,
  input logic       progWindow,
  input logic       testFeatEn,
  input logic       seqDone,
  input logic [2:0] seqState
);
  assert_hard_first_R1: assert property (@(posedge clk) disable iff (!rstN)
    !hardRstN |-> (!lowPwrRstN && !txPcsRstN && !rxPcsRstN && !progWindow));

  assert_window_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    progWindow |-> (hardRstN && !lowPwrRstN && !txPcsRstN && !rxPcsRstN));

  assert_lowpwr_after_window_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lowPwrRstN) |-> $past(progWindow));

  assert_tx_after_lowpwr_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txPcsRstN) |-> $past(lowPwrRstN));

  assert_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    testFeatEn == seqDone);

  assert_done_with_rx_R8: assert property (@(posedge clk) disable iff (!rstN)
    seqDone == rxPcsRstN);

  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (seqDone && !restart && refClkValid) |=> seqDone);

  assert_state_range_R9: assert property (@(posedge clk) disable iff (!rstN)
    seqState <= 3'd4);

  assert_abort_R10: assert property (@(posedge clk) disable iff (!rstN)
    (restart || !refClkValid) |=> (!hardRstN && !seqDone && seqState == 3'd0));
endmodule

bind lane_reset_sequencer lane_reset_sequencer_chk u_chk (.*);

// File: tb/sim_lane_reset_sequencer.sv
module sim_lane_reset_sequencer;
  localparam int PROG = 40;
  localparam int RXC  = 25;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic restart = 1'b0;
  logic refClkValid = 1'b1;
  logic hardRstN, lowPwrRstN, txPcsRstN, rxPcsRstN, progWindow, testFeatEn, seqDone;
  logic [2:0] seqState;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  always #10 clk = ~clk;

  lane_reset_sequencer #(
    .CLK_MHZ(50), .FAST_SIM(1'b1), .FAST_PROG_CYC(PROG), .FAST_RX_CYC(RXC)
  ) u0 (
    .clk(clk), .rstN(rstN), .restart(restart), .refClkValid(refClkValid),
    .hardRstN(hardRstN), .lowPwrRstN(lowPwrRstN), .txPcsRstN(txPcsRstN),
    .rxPcsRstN(rxPcsRstN), .progWindow(progWindow), .testFeatEn(testFeatEn),
    .seqDone(seqDone), .seqState(seqState)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // bench sequence model, built from the requirement text
  int mSt = 0;
  int mCnt = 0;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mSt <= 0; mCnt <= 0;
    end else if (restart || !refClkValid) begin
      mSt <= 0; mCnt <= 0;
    end else begin
      case (mSt)
        0: begin mSt <= 1; mCnt <= 0; end
        1: if (mCnt == PROG - 1) mSt <= 2; else mCnt <= mCnt + 1;
        2: begin mSt <= 3; mCnt <= 0; end
        3: if (mCnt == RXC - 1) mSt <= 4; else mCnt <= mCnt + 1;
        default: ;
      endcase
    end
  end

  function automatic int expHard(int s);  return int'(s != 0); endfunction
  function automatic int expLow(int s);   return int'(s >= 2); endfunction
  function automatic int expTx(int s);    return int'(s >= 3); endfunction
  function automatic int expRx(int s);    return int'(s == 4); endfunction
  function automatic int expProg(int s);  return int'(s == 1); endfunction

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      chk("R1 hardRstN",   int'(hardRstN),   expHard(mSt));
      chk("R2 progWindow", int'(progWindow), expProg(mSt));
      chk("R4 lowPwrRstN", int'(lowPwrRstN), expLow(mSt));
      chk("R5 txPcsRstN",  int'(txPcsRstN),  expTx(mSt));
      chk("R6 rxPcsRstN",  int'(rxPcsRstN),  expRx(mSt));
      chk("R8 seqDone",    int'(seqDone),    expRx(mSt));
      chk("R7 testFeatEn", int'(testFeatEn), expRx(mSt));
      chk("R9 seqState",   int'(seqState),   mSt);
    end
  end

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    while (cycles < 150000) @(negedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
    finishRun();
  end

  // directed full run: measures both waits and the hold of completion
  task automatic fullRun();
    int n;
    @(negedge clk); restart = 1'b1;
    @(negedge clk); restart = 1'b0;
    chk("R10 idle after restart", int'(seqState), 0);
    chk("R10 hard held", int'(hardRstN), 0);
    @(negedge clk);
    chk("R1 hard released first", int'({hardRstN, lowPwrRstN, txPcsRstN, rxPcsRstN}), 8);
    n = 0;
    while (progWindow && n < 1000) begin
      chk("R3 others held in window", int'({lowPwrRstN, txPcsRstN, rxPcsRstN}), 0);
      n++; @(negedge clk);
    end
    chk("R2 window length", n, PROG);
    chk("R4 lowPwr right after window", int'(lowPwrRstN), 1);
    chk("R5 tx still held", int'(txPcsRstN), 0);
    @(negedge clk);
    chk("R5 tx one cycle later", int'(txPcsRstN), 1);
    n = 0;
    while (!rxPcsRstN && n < 1000) begin
      chk("R7 gate low before done", int'(testFeatEn), 0);
      n++; @(negedge clk);
    end
    chk("R6 rx wait length", n, RXC);
    chk("R8 done with rx", int'(seqDone), 1);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      chk("R8 done holds", int'(seqDone), 1);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R10 reset state", int'({hardRstN, lowPwrRstN, txPcsRstN, rxPcsRstN, progWindow, seqDone, testFeatEn}), 0);
    chk("R9 reset encoding", int'(seqState), 0);
    rstN = 1'b1;
    fullRun();

    // clock-valid drop from done
    @(negedge clk); refClkValid = 1'b0;
    @(negedge clk);
    chk("R10 valid drop clears done", int'(seqDone), 0);
    chk("R10 valid drop holds hard", int'(hardRstN), 0);
    refClkValid = 1'b1;
    fullRun();

    // random restarts and clock-valid drops at arbitrary points
    for (int it = 0; it < 60; it++) begin
      int gap;
      int len;
      gap = int'($urandom_range(0, 90));
      len = int'($urandom_range(1, 3));
      repeat (gap) @(negedge clk);
      if ($urandom_range(0, 1) == 1) restart = 1'b1; else refClkValid = 1'b0;
      repeat (len) @(negedge clk);
      chk("R10 aborted to idle", int'(seqState), 0);
      restart = 1'b0; refClkValid = 1'b1;
    end

    fullRun();
    finishRun();
  end
endmodule